// File: doc/BRIEF.md
# Per-Target Interrupt Priority Resolver with Claim and Completion

This block is the arbitration core of a platform interrupt controller. It takes a vector of pending requests from the per-source gateways, a priority value for each source, and for each target a row of enable bits and a priority threshold. Every clock cycle it chooses, for each target separately, the enabled pending source with the largest priority that lies strictly above that target's threshold. It publishes that source's number as the target's ID and raises the target's IRQ while the ID is nonzero. Sources are numbered from 1, and ID 0 means that nothing qualifies.

A target claims the published source with a one-cycle claim strobe, which stands for the read of its ID. The block records which source that target now owns and sends a one-cycle pulse to that source's gateway. It also withholds the source from every target until the work is done. A one-cycle completion strobe, which stands for the write to the ID, frees the recorded source and sends a pulse to its gateway. The data written has no meaning, so it does not reach this block. Bus decoding stays outside the block.

Top module: `prio_route_core`

## Requirements
- R1: Among qualifying sources for a target, the one with the numerically larger priority value is published.
- R2: A source qualifies for a target only if its priority is strictly greater than that target's threshold, so a threshold of 0 masks nothing and a source whose priority equals the threshold is masked.
- R3: A source qualifies for a target only if that target's enable bit for it (bit s-1 of the target's enable row, for source s) is set, and each target's row acts independently.
- R4: When qualifying sources share the highest priority, the lower ID wins. The source on request bit s is ID s+1.
- R5: A source with priority 0 never qualifies.
- R6: When no source qualifies, the target's ID is 0 and its IRQ is low. IRQ is high exactly when the ID is nonzero. IDs are $clog2(SOURCES+1) bits wide.
- R7: ID and IRQ are registered. They reflect the inputs sampled at the previous rising edge.
- R8: A claim strobe while the target publishes a nonzero ID records that ID for the target. In the next cycle it raises the gateway claim bit (bit ID-1) for exactly one cycle. That source stops qualifying for every target until it is completed, so the ID moves to the next qualifying source, or to 0 with IRQ low.
- R9: A completion strobe from a target that holds a claim pulses the gateway completion bit of the recorded source for one cycle in the next cycle and makes that source eligible again. A completion strobe from a target that holds no claim has no effect.
- R10: A claim strobe is ignored when the target's ID is 0 or when the target already holds an uncompleted claim.
- R11: When several targets claim the same source in the same cycle, only the lowest-numbered target obtains it, and the others record nothing.
- R12: A synchronous active-high reset clears all IDs, IRQs, claim records and gateway pulses, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | SOURCES | Pending request from each gateway; bit s is ID s+1 |
| src_prio | input | SOURCES*PRIO_W | Priority of each source; field s at [s*PRIO_W +: PRIO_W] |
| tgt_en | input | TARGETS*SOURCES | Enable rows; row t at [t*SOURCES +: SOURCES] |
| tgt_thresh | input | TARGETS*PRIO_W | Threshold of each target; field t at [t*PRIO_W +: PRIO_W] |
| claim_stb | input | TARGETS | One-cycle claim (ID read) per target |
| complete_stb | input | TARGETS | One-cycle completion (ID write) per target |
| tgt_id | output | TARGETS*ID_W | Published ID of each target; field t at [t*ID_W +: ID_W] |
| tgt_irq | output | TARGETS | Interrupt notification per target |
| gw_claim | output | SOURCES | One-cycle claim pulse to each gateway |
| gw_complete | output | SOURCES | One-cycle completion pulse to each gateway |

## Verification
The bench uses the defaults: eight sources, two targets and eight priority levels. With these values a ramp of priorities 0 to 7 covers every level, and the top ID of 8 needs the full 4-bit ID field. Two targets make room for different enable rows and thresholds side by side, and for two claims of one source in the same cycle. Because the priorities range down to 0, the masking of priority-0 sources and the strict threshold at both ends of the range can be checked.

// File: rtl/prc_pkg.sv
package prc_pkg;
  // Width of an ID field able to hold 0 (nothing pending) up to n.
  function automatic int id_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/prc_picker.sv
// Combinational maximum search over the sources for one target.
// Starting from the threshold makes the strict threshold rule, and the
// lower-ID-wins rule on ties, fall out of one ascending scan.
module prc_picker #(
  parameter int SOURCES = 8,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4
) (
  input  logic [SOURCES-1:0]        req,
  input  logic [SOURCES-1:0]        busy,
  input  logic [SOURCES-1:0]        en,
  input  logic [SOURCES*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         thresh,
  output logic [ID_W-1:0]           sel_id,
  output logic [PRIO_W-1:0]         sel_prio
);
  logic [SOURCES-1:0] eligible;

  assign eligible = req & en & ~busy;

  always_comb begin
    sel_prio = thresh;
    sel_id   = '0;
    for (int s = 0; s < SOURCES; s++) begin
      if (eligible[s] && (prio[s*PRIO_W +: PRIO_W] > sel_prio)) begin
        sel_prio = prio[s*PRIO_W +: PRIO_W];
        sel_id   = ID_W'(s + 1);
      end
    end
  end
endmodule

// File: rtl/prc_target_slot.sv
// Registered ID/IRQ of one target plus its record of the claimed source.
module prc_target_slot #(
  parameter int SOURCES = 8,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   sel_id,
  input  logic [PRIO_W-1:0] sel_prio,
  input  logic [PRIO_W-1:0] thresh,
  input  logic              claim_grant,
  input  logic              complete_stb,
  output logic [ID_W-1:0]   id_q,
  output logic              irq_q,
  output logic              held_q,
  output logic [ID_W-1:0]   held_id_q,
  output logic              complete_fire
);
  assign complete_fire = complete_stb & held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q      <= '0;
      irq_q     <= 1'b0;
      held_q    <= 1'b0;
      held_id_q <= '0;
    end else begin
      id_q  <= sel_id;
      irq_q <= (sel_id != '0);
      if (complete_fire) begin
        held_q    <= 1'b0;
        held_id_q <= '0;
      end else if (claim_grant) begin
        held_q    <= 1'b1;
        held_id_q <= id_q;
      end
    end
  end

  AST_PICK_ABOVE_THRESH: assert property (@(posedge clk) disable iff (rst)
    (sel_id != '0) |-> (sel_prio > thresh)); // R2

  AST_ID_RANGE: assert property (@(posedge clk) disable iff (rst)
    id_q <= ID_W'(SOURCES)); // R6

  AST_GRANT_NEEDS_ID: assert property (@(posedge clk) disable iff (rst)
    claim_grant |-> (id_q != '0 && !held_q)); // R10

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (held_q && !complete_stb) |=> (held_q && $stable(held_id_q))); // R10
endmodule

// File: rtl/prc_claim_router.sv
// Arbitrates claims across targets, keeps the per-source in-service bits
// and drives the registered one-cycle pulses towards the gateways.
module prc_claim_router #(
  parameter int SOURCES = 8,
  parameter int TARGETS = 2,
  parameter int ID_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [TARGETS-1:0]      claim_stb,
  input  logic [TARGETS*ID_W-1:0] id_flat,
  input  logic [TARGETS-1:0]      held,
  input  logic [TARGETS-1:0]      complete_fire,
  input  logic [TARGETS*ID_W-1:0] held_id_flat,
  output logic [TARGETS-1:0]      claim_grant,
  output logic [SOURCES-1:0]      busy,
  output logic [SOURCES-1:0]      gw_claim,
  output logic [SOURCES-1:0]      gw_complete
);
  logic [SOURCES-1:0] take;
  logic [SOURCES-1:0] drop;

  // Lower target index is visited first and so wins a shared source.
  always_comb begin
    claim_grant = '0;
    take        = '0;
    for (int t = 0; t < TARGETS; t++) begin
      automatic int idx = int'(id_flat[t*ID_W +: ID_W]) - 1;
      if (claim_stb[t] && !held[t] && idx >= 0 && idx < SOURCES) begin
        if (!busy[idx] && !take[idx]) begin
          claim_grant[t] = 1'b1;
          take[idx]      = 1'b1;
        end
      end
    end
  end

  always_comb begin
    drop = '0;
    for (int t = 0; t < TARGETS; t++) begin
      automatic int idx = int'(held_id_flat[t*ID_W +: ID_W]) - 1;
      if (complete_fire[t] && idx >= 0 && idx < SOURCES) drop[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= '0;
      gw_claim    <= '0;
      gw_complete <= '0;
    end else begin
      busy        <= (busy | take) & ~drop;
      gw_claim    <= take;
      gw_complete <= drop;
    end
  end

  AST_NO_DOUBLE_CLAIM: assert property (@(posedge clk) disable iff (rst)
    (gw_claim & $past(busy)) == '0); // R11

  AST_COMPLETE_WAS_HELD: assert property (@(posedge clk) disable iff (rst)
    (gw_complete & ~$past(busy)) == '0); // R9

  AST_COMPLETE_FREES: assert property (@(posedge clk) disable iff (rst)
    (gw_complete & busy) == '0); // R9
endmodule

// File: rtl/prio_route_core.sv
module prio_route_core #(
  parameter  int SOURCES    = 8,
  parameter  int TARGETS    = 2,
  parameter  int PRIORITIES = 8,
  localparam int PRIO_W     = $clog2(PRIORITIES),
  localparam int ID_W       = prc_pkg::id_bits(SOURCES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SOURCES-1:0]        src_req,
  input  logic [SOURCES*PRIO_W-1:0] src_prio,
  input  logic [TARGETS*SOURCES-1:0] tgt_en,
  input  logic [TARGETS*PRIO_W-1:0] tgt_thresh,
  input  logic [TARGETS-1:0]        claim_stb,
  input  logic [TARGETS-1:0]        complete_stb,
  output logic [TARGETS*ID_W-1:0]   tgt_id,
  output logic [TARGETS-1:0]        tgt_irq,
  output logic [SOURCES-1:0]        gw_claim,
  output logic [SOURCES-1:0]        gw_complete
);
  logic [SOURCES-1:0]      busy;
  logic [TARGETS-1:0]      claim_grant;
  logic [TARGETS-1:0]      held;
  logic [TARGETS-1:0]      complete_fire;
  logic [TARGETS*ID_W-1:0] held_id_flat;

  for (genvar t = 0; t < TARGETS; t++) begin : g_tgt
    logic [ID_W-1:0]   sel_id;
    logic [PRIO_W-1:0] sel_prio;

    prc_picker #(
      .SOURCES(SOURCES), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_pick (
      .req     (src_req),
      .busy    (busy),
      .en      (tgt_en[t*SOURCES +: SOURCES]),
      .prio    (src_prio),
      .thresh  (tgt_thresh[t*PRIO_W +: PRIO_W]),
      .sel_id  (sel_id),
      .sel_prio(sel_prio)
    );

    prc_target_slot #(
      .SOURCES(SOURCES), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_slot (
      .clk          (clk),
      .rst          (rst),
      .sel_id       (sel_id),
      .sel_prio     (sel_prio),
      .thresh       (tgt_thresh[t*PRIO_W +: PRIO_W]),
      .claim_grant  (claim_grant[t]),
      .complete_stb (complete_stb[t]),
      .id_q         (tgt_id[t*ID_W +: ID_W]),
      .irq_q        (tgt_irq[t]),
      .held_q       (held[t]),
      .held_id_q    (held_id_flat[t*ID_W +: ID_W]),
      .complete_fire(complete_fire[t])
    );
  end

  prc_claim_router #(
    .SOURCES(SOURCES), .TARGETS(TARGETS), .ID_W(ID_W)
  ) u_route (
    .clk          (clk),
    .rst          (rst),
    .claim_stb    (claim_stb),
    .id_flat      (tgt_id),
    .held         (held),
    .complete_fire(complete_fire),
    .held_id_flat (held_id_flat),
    .claim_grant  (claim_grant),
    .busy         (busy),
    .gw_claim     (gw_claim),
    .gw_complete  (gw_complete)
  );
endmodule

// File: tb/prio_route_core_tb.sv
`timescale 1ns/1ps
module prio_route_core_tb;
  localparam int S = 8;
  localparam int T = 2;
  localparam int PW = 3;
  localparam int IW = 4;
  localparam logic [23:0] RAMP = {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0};

  typedef struct packed {
    logic [7:0]  req;
    logic [23:0] prio;
    logic [7:0]  en0;
    logic [7:0]  en1;
    logic [2:0]  th0;
    logic [2:0]  th1;
    logic [3:0]  e0;
    logic [3:0]  e1;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h00, {8{3'd3}}, 8'hFF, 8'hFF, 3'd0, 3'd0, 4'd0, 4'd0, 4'd6},  // R6 nothing pending
    '{8'h01, {8{3'd1}}, 8'hFF, 8'hFF, 3'd0, 3'd0, 4'd1, 4'd1, 4'd2},  // R2 threshold 0
    '{8'h0C, {8{3'd5}}, 8'hFF, 8'hFF, 3'd0, 3'd5, 4'd3, 4'd0, 4'd4},  // R4 tie, R2 equal masked
    '{8'h02, {3'd4,3'd4,3'd4,3'd4,3'd4,3'd4,3'd0,3'd4}, 8'hFF, 8'hFF, 3'd0, 3'd0, 4'd0, 4'd0, 4'd5}, // R5
    '{8'hFF, RAMP, 8'hFF, 8'h7F, 3'd0, 3'd3, 4'd8, 4'd7, 4'd1},       // R1
    '{8'hFF, RAMP, 8'h0F, 8'h00, 3'd0, 3'd0, 4'd4, 4'd0, 4'd3},       // R3
    '{8'hFF, RAMP, 8'hFF, 8'hFF, 3'd6, 3'd7, 4'd8, 4'd0, 4'd2},       // R2 high thresholds
    '{8'hA0, {3'd2,3'd0,3'd6,15'd0}, 8'hFF, 8'hFF, 3'd0, 3'd1, 4'd6, 4'd6, 4'd1} // R1 not by index
  };

  logic           clk = 1'b0;
  logic           rst;
  logic [S-1:0]   src_req;
  logic [S*PW-1:0] src_prio;
  logic [T*S-1:0] tgt_en;
  logic [T*PW-1:0] tgt_thresh;
  logic [T-1:0]   claim_stb;
  logic [T-1:0]   complete_stb;
  logic [T*IW-1:0] tgt_id;
  logic [T-1:0]   tgt_irq;
  logic [S-1:0]   gw_claim;
  logic [S-1:0]   gw_complete;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  prio_route_core #(.SOURCES(S), .TARGETS(T), .PRIORITIES(8)) u_dut (
    .clk(clk), .rst(rst), .src_req(src_req), .src_prio(src_prio),
    .tgt_en(tgt_en), .tgt_thresh(tgt_thresh), .claim_stb(claim_stb),
    .complete_stb(complete_stb), .tgt_id(tgt_id), .tgt_irq(tgt_irq),
    .gw_claim(gw_claim), .gw_complete(gw_complete)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; claim_stb = '0; complete_stb = '0;
    src_req = 8'hFF; src_prio = RAMP; tgt_en = {8'hFF, 8'hFF}; tgt_thresh = '0;
    repeat (3) tick();
    // R12: reset holds outputs low despite qualifying inputs
    check("R12 id", int'(tgt_id), 0);
    check("R12 irq", int'(tgt_irq), 0);
    check("R12 gw", int'({gw_claim, gw_complete}), 0);
    rst = 1'b0;
    tick();
    // R7: one edge after reset release the ID reflects the inputs
    check("R7 id0", int'(tgt_id[3:0]), 8);
    check("R7 irq0", int'(tgt_irq[0]), 1);

    for (int v = 0; v < NV; v++) begin
      src_req = VEC[v].req; src_prio = VEC[v].prio;
      tgt_en = {VEC[v].en1, VEC[v].en0};
      tgt_thresh = {VEC[v].th1, VEC[v].th0};
      tick();
      check($sformatf("R%0d vec%0d id0", VEC[v].rq, v), int'(tgt_id[3:0]), int'(VEC[v].e0));
      check($sformatf("R%0d vec%0d id1", VEC[v].rq, v), int'(tgt_id[7:4]), int'(VEC[v].e1));
      check($sformatf("R%0d vec%0d irq0", VEC[v].rq, v), int'(tgt_irq[0]), int'(VEC[v].e0 != 0));
      check($sformatf("R%0d vec%0d irq1", VEC[v].rq, v), int'(tgt_irq[1]), int'(VEC[v].e1 != 0));
    end

    // Claim/complete flow on target 0: sources 3 (prio 2) and 5 (prio 4)
    src_req = 8'h14; src_prio = RAMP; tgt_en = {8'h00, 8'hFF}; tgt_thresh = '0;
    tick();
    check("R1 claim setup id0", int'(tgt_id[3:0]), 5);
    claim_stb = 2'b01; tick(); claim_stb = '0;
    check("R8 gw_claim pulse", int'(gw_claim), 8'h10);
    check("R7 id0 before update", int'(tgt_id[3:0]), 5);
    tick();
    check("R8 id0 moves on", int'(tgt_id[3:0]), 3);
    check("R8 irq0 stays", int'(tgt_irq[0]), 1);
    check("R8 gw_claim one cycle", int'(gw_claim), 0);
    claim_stb = 2'b01; tick(); claim_stb = '0;
    check("R10 claim while held", int'(gw_claim), 0);
    tick();
    check("R10 id0 unchanged", int'(tgt_id[3:0]), 3);
    complete_stb = 2'b01; tick(); complete_stb = '0;
    check("R9 gw_complete pulse", int'(gw_complete), 8'h10);
    tick();
    check("R9 source eligible again", int'(tgt_id[3:0]), 5);
    check("R9 gw_complete one cycle", int'(gw_complete), 0);
    complete_stb = 2'b10; tick(); complete_stb = '0;
    check("R9 complete without claim", int'(gw_complete), 0);

    // Single source: claim drops IRQ
    src_req = 8'h10; tick();
    claim_stb = 2'b01; tick(); claim_stb = '0;
    tick();
    check("R8 irq0 falls", int'(tgt_irq[0]), 0);
    check("R8 id0 zero", int'(tgt_id[3:0]), 0);
    complete_stb = 2'b01; tick(); complete_stb = '0;
    tick();
    check("R9 id0 back", int'(tgt_id[3:0]), 5);
    src_req = 8'h00; tick();
    claim_stb = 2'b01; tick(); claim_stb = '0;
    check("R10 claim on id 0", int'(gw_claim), 0);

    // Two targets claim source 2 in the same cycle
    src_req = 8'h02; tgt_en = {8'hFF, 8'hFF}; tick(); tick();
    check("R11 setup id1", int'(tgt_id[7:4]), 2);
    claim_stb = 2'b11; tick(); claim_stb = '0;
    check("R11 single gw_claim", int'(gw_claim), 8'h02);
    tick();
    check("R8 excluded id0", int'(tgt_id[3:0]), 0);
    check("R8 excluded id1", int'(tgt_id[7:4]), 0);
    complete_stb = 2'b10; tick(); complete_stb = '0;
    check("R11 loser holds nothing", int'(gw_complete), 0);
    complete_stb = 2'b01; tick(); complete_stb = '0;
    check("R11 winner completes", int'(gw_complete), 8'h02);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule